// File: doc/BRIEF.md
# SPI Master Clock and Transfer Timing Sequencer

This block drives the serial clock and the peripheral select line of an SPI master. A data path and a command queue sit around it. For each command it asserts the select line and waits a lead delay. It then toggles SCK a set number of times at a programmable rate. It drops the select line half a clock period after the last edge, waits a trail delay and reports completion. It produces no data. A neighbouring shifter moves one bit per SCK cycle on the `shift_stb` strobe.

The three timing fields sit in a small configuration register that `cfg_wr` loads. The fields are the half-period divider, the user lead delay and the user trail delay. Each start strobe carries two flags. One picks the standard or the user lead delay and the other picks the standard or the user trail delay. The strobe also carries a bit-count code.

The state machine has four states:
- `ST_IDLE` goes to `ST_LEAD` on an accepted start.
- `ST_LEAD` goes to `ST_SHIFT` when the lead count expires.
- `ST_SHIFT` goes to `ST_TRAIL` when the last half-period expires.
- `ST_TRAIL` goes back to `ST_IDLE` and pulses `done` when the trail count expires.

Top module: `spi_sck_sequencer`

## Requirements
- R1: After reset, without any `cfg_wr`, the divider holds 4. A transfer then has SCK half-periods of 4 clocks, which is one eighth of the clock rate. The lead field resets to 0 and the trail field resets to 1.
- R2: With divider value D in 2..255, SCK changes level D clocks apart, 2N times per transfer. Taking the start-sampling edge as cycle 0, the changes fall at cycles L + k·D for k = 0..2N-1.
- R3: With divider value 0 or 1, start is ignored. `cs_n` stays high, SCK stays at the `cpol` level and `done` stays low.
- R4: With `lead_user`=0, the lead delay L from select assertion to the first SCK edge equals D clocks, which is half an SCK period.
- R5: With `lead_user`=1, L equals the lead field in clocks, except that a field value of 0 gives 128 and a value of 1 gives 2.
- R6: With `trail_user`=0, the trail delay T is 17 clocks. With `trail_user`=1, T is 32 × the trail field, and a field value of 0 gives 8192. `done` is high for one clock at cycle L + 2N·D + T.
- R7: `cs_n` goes low in cycle 0 and high at cycle L + 2N·D. Whenever `cs_n` is high, SCK equals `cpol`.
- R8: The 4-bit count code gives N. Code 0 means 16, codes 1 to 7 mean 8, and codes 8 to 15 mean that many cycles.
- R9: `shift_stb` pulses N times, once in each clock in which SCK returns to the `cpol` level, at cycles L + (2k+1)·D.
- R10: A start raised while a transfer or its trail delay is in progress is ignored. Each accepted start yields exactly one `done` pulse.
- R11: `cfg_wr` loads the divider, lead and trail fields in one clock. The new values govern the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Load strobe for the three timing fields |
| cfg_div | input | 8 | Half-period divider (0 and 1 switch the clock off) |
| cfg_lead | input | 7 | User lead delay in clocks |
| cfg_trail | input | 8 | User trail delay in units of 32 clocks |
| cpol | input | 1 | SCK idle level |
| start | input | 1 | Start strobe for one transfer |
| lead_user | input | 1 | 1 selects the user lead delay |
| trail_user | input | 1 | 1 selects the user trail delay |
| bits | input | 4 | SCK-cycle count code |
| sck | output | 1 | Serial clock |
| cs_n | output | 1 | Peripheral select, active low |
| shift_stb | output | 1 | One-clock strobe on each returning SCK edge |
| done | output | 1 | One-clock completion pulse |

## Verification
Every result is timed from the clock edge that samples `start`, taken as cycle 0.
- `cs_n` is low from cycle 0 onward.
- The k-th SCK change is due at L + k·D.
- The k-th shift strobe is due at L + (2k+1)·D.
- `cs_n` returns high at L + 2N·D.
- `done` is due at L + 2N·D + T.

The bench drives inputs on falling edges. It counts cycles on each falling edge after the sampling edge and compares every observed event time with these formulas. It sweeps the divider, the count code, each lead variant and the clock polarity.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_TRAIL = 2'd3
    } seq_state_t;
endpackage

// File: rtl/spi_seq_cfg.sv
module spi_seq_cfg #(
    parameter int DIV_W   = 8,
    parameter int LEAD_W  = 7,
    parameter int TRAIL_W = 8,
    parameter int RST_DIV   = 4,
    parameter int RST_LEAD  = 0,
    parameter int RST_TRAIL = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [DIV_W-1:0]   div_in,
    input  logic [LEAD_W-1:0]  lead_in,
    input  logic [TRAIL_W-1:0] trail_in,
    output logic [DIV_W-1:0]   div_q,
    output logic [LEAD_W-1:0]  lead_q,
    output logic [TRAIL_W-1:0] trail_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q   <= DIV_W'(RST_DIV);
            lead_q  <= LEAD_W'(RST_LEAD);
            trail_q <= TRAIL_W'(RST_TRAIL);
        end else if (wr) begin
            div_q   <= div_in;
            lead_q  <= lead_in;
            trail_q <= trail_in;
        end
    end
endmodule

// File: rtl/spi_seq_len.sv
module spi_seq_len #(
    parameter int DIV_W     = 8,
    parameter int LEAD_W    = 7,
    parameter int TRAIL_W   = 8,
    parameter int TRAIL_SH  = 5,
    parameter int STD_TRAIL = 17,
    parameter int BITS_W    = 4,
    parameter int MIN_BITS  = 8,
    parameter int CNT_W     = TRAIL_W + TRAIL_SH,
    parameter int EDGE_W    = BITS_W + 2
) (
    input  logic [DIV_W-1:0]   div_q,
    input  logic [LEAD_W-1:0]  lead_q,
    input  logic [TRAIL_W-1:0] trail_q,
    input  logic               lead_user,
    input  logic               trail_user,
    input  logic [BITS_W-1:0]  bits,
    output logic [CNT_W-1:0]   lead_m1,
    output logic [CNT_W-1:0]   trail_m1,
    output logic [EDGE_W-1:0]  edges_m1
);
    localparam int LEAD_ZERO  = 2 ** LEAD_W;
    localparam int TRAIL_ZERO = (2 ** TRAIL_W) * (2 ** TRAIL_SH);
    localparam int FULL_BITS  = 2 ** BITS_W;

    logic [EDGE_W-1:0] ncyc;

    always_comb begin
        if (!lead_user)
            lead_m1 = CNT_W'(div_q) - 1'b1;
        else if (lead_q == '0)
            lead_m1 = CNT_W'(LEAD_ZERO - 1);
        else if (lead_q == LEAD_W'(1))
            lead_m1 = CNT_W'(1);
        else
            lead_m1 = CNT_W'(lead_q) - 1'b1;

        if (!trail_user)
            trail_m1 = CNT_W'(STD_TRAIL - 1);
        else if (trail_q == '0)
            trail_m1 = CNT_W'(TRAIL_ZERO - 1);
        else
            trail_m1 = (CNT_W'(trail_q) << TRAIL_SH) - 1'b1;

        if (bits == '0)
            ncyc = EDGE_W'(FULL_BITS);
        else if (bits < BITS_W'(MIN_BITS))
            ncyc = EDGE_W'(MIN_BITS);
        else
            ncyc = EDGE_W'(bits);
        edges_m1 = (ncyc << 1) - 1'b1;
    end
endmodule

// File: rtl/spi_sck_sequencer.sv
module spi_sck_sequencer
    import spi_seq_pkg::*;
#(
    parameter int DIV_W     = 8,
    parameter int LEAD_W    = 7,
    parameter int TRAIL_W   = 8,
    parameter int TRAIL_SH  = 5,
    parameter int STD_TRAIL = 17,
    parameter int BITS_W    = 4,
    parameter int MIN_BITS  = 8,
    parameter int RST_DIV   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr,
    input  logic [DIV_W-1:0]   cfg_div,
    input  logic [LEAD_W-1:0]  cfg_lead,
    input  logic [TRAIL_W-1:0] cfg_trail,
    input  logic               cpol,
    input  logic               start,
    input  logic               lead_user,
    input  logic               trail_user,
    input  logic [BITS_W-1:0]  bits,
    output logic               sck,
    output logic               cs_n,
    output logic               shift_stb,
    output logic               done
);
    localparam int CNT_W  = TRAIL_W + TRAIL_SH;
    localparam int EDGE_W = BITS_W + 2;

    logic [DIV_W-1:0]   div_q;
    logic [LEAD_W-1:0]  lead_q;
    logic [TRAIL_W-1:0] trail_q;
    logic [CNT_W-1:0]   lead_m1, trail_m1, trail_hold;
    logic [EDGE_W-1:0]  edges_m1, edges_left;
    logic [CNT_W-1:0]   cnt;
    logic               phase;
    logic               clk_on;
    logic               cnt_zero;
    seq_state_t         state;

    spi_seq_cfg #(
        .DIV_W(DIV_W), .LEAD_W(LEAD_W), .TRAIL_W(TRAIL_W), .RST_DIV(RST_DIV)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr(cfg_wr),
        .div_in(cfg_div), .lead_in(cfg_lead), .trail_in(cfg_trail),
        .div_q(div_q), .lead_q(lead_q), .trail_q(trail_q)
    );

    spi_seq_len #(
        .DIV_W(DIV_W), .LEAD_W(LEAD_W), .TRAIL_W(TRAIL_W), .TRAIL_SH(TRAIL_SH),
        .STD_TRAIL(STD_TRAIL), .BITS_W(BITS_W), .MIN_BITS(MIN_BITS)
    ) u_len (
        .div_q(div_q), .lead_q(lead_q), .trail_q(trail_q),
        .lead_user(lead_user), .trail_user(trail_user), .bits(bits),
        .lead_m1(lead_m1), .trail_m1(trail_m1), .edges_m1(edges_m1)
    );

    assign clk_on   = (div_q > DIV_W'(1));
    assign cnt_zero = (cnt == '0);

    // State register together with the timing counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            cnt        <= '0;
            edges_left <= '0;
            trail_hold <= '0;
            phase      <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start && clk_on) begin
                        state      <= ST_LEAD;
                        cnt        <= lead_m1;
                        edges_left <= edges_m1;
                        trail_hold <= trail_m1;
                        phase      <= 1'b0;
                    end
                end
                ST_LEAD: begin
                    if (cnt_zero) begin
                        state <= ST_SHIFT;
                        phase <= 1'b1;
                        cnt   <= CNT_W'(div_q) - 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_SHIFT: begin
                    if (!cnt_zero) begin
                        cnt <= cnt - 1'b1;
                    end else if (edges_left == '0) begin
                        state <= ST_TRAIL;
                        cnt   <= trail_hold;
                    end else begin
                        phase      <= ~phase;
                        edges_left <= edges_left - 1'b1;
                        cnt        <= CNT_W'(div_q) - 1'b1;
                    end
                end
                ST_TRAIL: begin
                    if (cnt_zero) state <= ST_IDLE;
                    else          cnt   <= cnt - 1'b1;
                end
            endcase
        end
    end

    // Registered strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_stb <= 1'b0;
            done      <= 1'b0;
        end else begin
            shift_stb <= (state == ST_SHIFT) && cnt_zero && (edges_left != '0) && phase;
            done      <= (state == ST_TRAIL) && cnt_zero;
        end
    end

    // Pin outputs
    always_comb begin
        sck  = cpol ^ phase;
        cs_n = !((state == ST_LEAD) || (state == ST_SHIFT));
    end
endmodule

// File: rtl/spi_sck_seq_chk.sv
module spi_sck_seq_chk #(
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             cpol,
    input logic             sck,
    input logic             cs_n,
    input logic             shift_stb,
    input logic             done,
    input logic [DIV_W-1:0] div_q
);
    p_idle_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (sck == cpol));

    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_deselected_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cs_n);

    p_shift_selected_r9: assert property (@(posedge clk) disable iff (!rst_n)
        shift_stb |-> !cs_n);

    p_clock_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && (div_q < DIV_W'(2))) |=> cs_n);

    p_select_needs_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> $past(start));
endmodule

bind spi_sck_sequencer spi_sck_seq_chk #(.DIV_W(DIV_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .cpol(cpol), .sck(sck),
    .cs_n(cs_n), .shift_stb(shift_stb), .done(done), .div_q(div_q)
);

// File: tb/sim_spi_sck_sequencer.sv
module sim_spi_sck_sequencer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_div = '0;
    logic [6:0] cfg_lead = '0;
    logic [7:0] cfg_trail = '0;
    logic       cpol = 1'b0;
    logic       start = 1'b0;
    logic       lead_user = 1'b0;
    logic       trail_user = 1'b0;
    logic [3:0] bits = '0;
    logic       sck, cs_n, shift_stb, done;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    spi_sck_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_div(cfg_div),
        .cfg_lead(cfg_lead), .cfg_trail(cfg_trail), .cpol(cpol), .start(start),
        .lead_user(lead_user), .trail_user(trail_user), .bits(bits),
        .sck(sck), .cs_n(cs_n), .shift_stb(shift_stb), .done(done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr_cfg(input int d, input int l, input int t);
        @(negedge clk);
        cfg_div = 8'(d); cfg_lead = 7'(l); cfg_trail = 8'(t); cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    function automatic int ncyc(input int b);
        if (b == 0) return 16;
        if (b < 8) return 8;
        return b;
    endfunction

    // Runs one transfer and compares every event time with the formulas
    task automatic run_xfer(input int L, input int N, input int D, input int T,
                            input string lreq, input bit poke);
        int tog = 0, bad_tog = 0, first_tog = -1;
        int sp = 0, bad_sp = 0;
        int cs_rise = -1, cs_refall = 0, done_t = -1, done_cnt = 0;
        int last = L + 2 * N * D + T + 30;
        logic prev;
        prev = cpol;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(cs_n == 1'b0, "R7 select at cycle 0", int'(cs_n), 0);
        for (int t = 0; t < last; t++) begin
            if (t > 0) @(negedge clk);
            if (poke) start = (t == 3);
            if (sck != prev) begin
                if (first_tog < 0) first_tog = t;
                if (t != L + tog * D) bad_tog++;
                tog++;
                prev = sck;
            end
            if (shift_stb) begin
                if (t != L + (2 * sp + 1) * D) bad_sp++;
                sp++;
            end
            if (cs_n && cs_rise < 0) cs_rise = t;
            if (!cs_n && cs_rise >= 0) cs_refall++;
            if (done) begin
                done_cnt++;
                done_t = t;
            end
        end
        start = 1'b0;
        check(first_tog == L, lreq, first_tog, L);
        check(tog == 2 * N, "R8 SCK change count", tog, 2 * N);
        check(bad_tog == 0, "R2 SCK change timing", bad_tog, 0);
        check(sp == N && bad_sp == 0, "R9 shift strobes", sp * 1000 + bad_sp, N * 1000);
        check(cs_rise == L + 2 * N * D, "R7 deselect time", cs_rise, L + 2 * N * D);
        check(done_t == L + 2 * N * D + T, "R6 done time", done_t, L + 2 * N * D + T);
        check(done_cnt == 1 && cs_refall == 0, "R10 single done, no extra select",
              done_cnt * 1000 + cs_refall, 1000);
    endtask

    task automatic run_off(input int d);
        int lows = 0, sck_bad = 0, dones = 0;
        wr_cfg(d, 5, 1);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int t = 0; t < 40; t++) begin
            if (!cs_n) lows++;
            if (sck != cpol) sck_bad++;
            if (done) dones++;
            @(negedge clk);
        end
        check(lows == 0 && sck_bad == 0 && dones == 0, "R3 clock off",
              lows + sck_bad + dones, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int divs[4] = '{2, 3, 5, 9};
        int bcodes[4] = '{0, 3, 8, 13};
        int lcfg[5] = '{0, 0, 1, 2, 9};
        int idx = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(cs_n == 1'b1 && sck == 1'b0 && done == 1'b0 && shift_stb == 1'b0,
              "R7 reset state", {cs_n, sck, done, shift_stb}, 4'b1000);

        // R1: reset default divider 4, standard delays
        bits = 4'd8;
        run_xfer(4, 8, 4, 17, "R1 default lead", 1'b0);

        // Sweep of divider, count code, lead variant and polarity
        foreach (divs[i]) begin
            foreach (bcodes[j]) begin
                for (int v = 0; v < 5; v++) begin
                    int L;
                    wr_cfg(divs[i], lcfg[v], 1);
                    cpol = idx[0];
                    idx++;
                    bits = 4'(bcodes[j]);
                    lead_user = (v != 0);
                    trail_user = 1'b0;
                    if (v == 0) L = divs[i];
                    else if (lcfg[v] == 0) L = 128;
                    else if (lcfg[v] == 1) L = 2;
                    else L = lcfg[v];
                    run_xfer(L, ncyc(bcodes[j]), divs[i], 17,
                             (v == 0) ? "R4 half-period lead" : "R5 user lead", 1'b0);
                end
            end
        end

        // R6: user trail delays, R11: new config on next start
        cpol = 1'b0;
        lead_user = 1'b0;
        trail_user = 1'b1;
        bits = 4'd9;
        wr_cfg(2, 0, 1);
        run_xfer(2, 9, 2, 32, "R11 lead after cfg write", 1'b0);
        wr_cfg(3, 0, 3);
        run_xfer(3, 9, 3, 96, "R11 lead after cfg write", 1'b0);
        wr_cfg(2, 0, 0);
        run_xfer(2, 9, 2, 8192, "R6 trail zero case lead", 1'b0);

        // R10: start while busy is ignored
        trail_user = 1'b0;
        lead_user = 1'b1;
        wr_cfg(4, 20, 1);
        run_xfer(20, 9, 4, 17, "R10 lead with busy start", 1'b1);

        // R2: top divider value
        lead_user = 1'b0;
        bits = 4'd1;
        wr_cfg(255, 0, 1);
        run_xfer(255, 8, 255, 17, "R2 max divider lead", 1'b0);

        // R3: divider values that switch the clock off
        cpol = 1'b1;
        run_off(0);
        run_off(1);
        cpol = 1'b0;
        run_off(0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule